// File: doc/BRIEF.md
# Display Power Sequencing Controller

This block steps a display output path up and down through four stages: the pixel clock, the timing synchronization, the panel enable pin, and the backlight PWM. Software controls the stages through a small register port. One register has write-one-to-set request bits and a separate register has write-one-to-clear request bits. A read-only status register shows, per stage, whether the stage is actually running. The status trails the request, so software polls each status bit after each request before it moves on.

Some stages depend on others. The synchronization stage waits for the clock stage to run. The panel enable waits for synchronization, and then for a programmable number of frames counted on the frame-start pulse of the timing generator. When software asks for the panel enable to go off, the pin drops only at the next frame boundary. If synchronization is lost, the pin drops at once. The PWM stage is independent, and software orders it last in both bring-up and shutdown. A control register holds the guard count, a bit that turns the guard delay on or off, and a vertical-sync delay bit, which is passed to the timing generator.

The write port and the read port each work in a single cycle: a write lands at the clock edge, and read data is combinational from the read address.

Top module: `disp_pwr_seq`

## Requirements
- R1: After reset, all four stage outputs are low, the status register (address 2) reads 0, and the control register (address 3) reads guard count 1, guard-delay bit 1 and vertical-sync delay bit 0. With the default GUARD_W=8 this is the value 0x101.
- R2: A write to address 0 sets the request of each stage whose data bit is 1. The bit positions are: bit 0 clock, bit 1 sync, bit 2 panel enable, bit 3 PWM. Zero bits leave their requests unchanged. Reading address 0 returns the four request bits in the same positions.
- R3: A write to address 1 clears the request of each stage whose data bit is 1, using the same bit positions as R2. Zero bits have no effect.
- R4: The clock enable output and status bit 0 become equal to the clock request one cycle after the request changes.
- R5: The sync enable output (status bit 1) is high only while the sync request is set and the clock status was high on the previous cycle. A sync request made while the clock is off is held, and sync starts one cycle after the clock status rises.
- R6: When the guard delay is on and the guard count G is nonzero, the panel enable pin rises on the cycle after the G-th frame-start pulse. Only pulses seen while the panel request is set, the sync status is high and the pin is low are counted.
- R7: When the guard delay bit is 0, or G is 0, the panel enable pin rises one cycle after its request and the sync status are both high.
- R8: After the panel request is cleared, the pin stays high until a frame-start pulse and drops on the cycle after that pulse. If the sync status goes low, the pin drops one cycle later, whatever the frame pulses do.
- R9: The PWM enable output (status bit 3) follows the PWM request with a one-cycle lag and does not depend on the other stages.
- R10: A write to address 3 loads the guard count from bits GUARD_W-1:0, the guard-delay bit from bit GUARD_W and the vertical-sync delay bit from bit GUARD_W+1. The vertical-sync delay output equals the stored bit.
- R11: Reading address 2 returns the four run states in the R2 bit positions. Reading address 1 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe, sampled at the clock edge |
| wr_addr | input | 2 | Write register select |
| wr_data | input | GUARD_W+2 | Write data |
| rd_addr | input | 2 | Read register select |
| rd_data | output | GUARD_W+2 | Combinational read data |
| frame_start | input | 1 | One-cycle pulse at each frame start from the timing generator |
| pclk_en | output | 1 | Pixel clock enable |
| sync_en | output | 1 | Timing synchronization enable |
| disp_pin | output | 1 | Panel enable pin |
| pwm_en | output | 1 | Backlight PWM enable |
| vsync_shift | output | 1 | Vertical-sync delay setting for the timing generator |

## Verification
A lost or stuck request bit shows up in the address 0 readback on the cycle after the write. It also shows up one cycle later as a wrong stage output. A guard counter that counts the wrong pulses, or that misses a reset, moves the panel-pin rising edge by whole frames, so it is seen on the frame where the pin should have risen. A wrong dependency between stages, such as sync running without the clock or the pin staying up after sync is lost, differs from the behavioural model within one cycle. The bench compares every output and the read data against that model on every clock, through directed bring-up and shutdown sequences and a long random phase of writes and frame pulses.

// File: rtl/disp_pwr_seq_pkg.sv
// Shared definitions for the display power sequencer: register selects
// and stage bit positions. Assumes a two-bit register address.
package disp_pwr_seq_pkg;

    typedef enum logic [1:0] {
        SEL_SET    = 2'd0,
        SEL_CLR    = 2'd1,
        SEL_STATUS = 2'd2,
        SEL_CTRL   = 2'd3
    } reg_sel_e;

    localparam int NUM_STAGES = 4;
    localparam int STG_CLK    = 0;
    localparam int STG_SYNC   = 1;
    localparam int STG_DISP   = 2;
    localparam int STG_PWM    = 3;

endpackage

// File: rtl/dps_regs.sv
// Register file of the sequencer. It holds the per-stage request bits,
// which are set and cleared by separate registers, and the control
// register (guard count, guard-delay bit, vertical-sync delay bit).
// Read data is combinational. Assumes the data width is GUARD_W+2, so
// that every written bit has a destination.
module dps_regs
    import disp_pwr_seq_pkg::*;
#(
    parameter  int GUARD_W = 8,
    localparam int DATA_W  = GUARD_W + 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [1:0]            wr_addr,
    input  logic [DATA_W-1:0]     wr_data,
    input  logic [1:0]            rd_addr,
    input  logic [NUM_STAGES-1:0] status,
    output logic [DATA_W-1:0]     rd_data,
    output logic [NUM_STAGES-1:0] req,
    output logic [GUARD_W-1:0]    guard,
    output logic                  delay_en,
    output logic                  vsync_shift
);

    logic [NUM_STAGES-1:0] wr_bits;
    logic                  set_hit;
    logic                  clr_hit;
    logic                  ctrl_hit;

    // Decode which register, if any, the current write targets.
    always_comb begin
        wr_bits  = wr_data[NUM_STAGES-1:0];
        set_hit  = wr_en && (reg_sel_e'(wr_addr) == SEL_SET);
        clr_hit  = wr_en && (reg_sel_e'(wr_addr) == SEL_CLR);
        ctrl_hit = wr_en && (reg_sel_e'(wr_addr) == SEL_CTRL);
    end

    // Request bits: the set register ORs bits in, the clear register masks them out.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req <= '0;
        end else if (set_hit) begin
            req <= req | wr_bits;
        end else if (clr_hit) begin
            req <= req & ~wr_bits;
        end
    end

    // Control register, loaded as one word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            guard       <= GUARD_W'(1);
            delay_en    <= 1'b1;
            vsync_shift <= 1'b0;
        end else if (ctrl_hit) begin
            guard       <= wr_data[GUARD_W-1:0];
            delay_en    <= wr_data[GUARD_W];
            vsync_shift <= wr_data[GUARD_W+1];
        end
    end

    // Read multiplexer; the clear register reads as zero.
    always_comb begin
        case (reg_sel_e'(rd_addr))
            SEL_SET:    rd_data = DATA_W'(req);
            SEL_STATUS: rd_data = DATA_W'(status);
            SEL_CTRL:   rd_data = {vsync_shift, delay_en, guard};
            default:    rd_data = '0;
        endcase
    end

    // R2: a set write never drops a request that was already set
    a_r2_set_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        set_hit |=> ((req & $past(req)) == $past(req)));

    // R3: a clear write leaves every addressed request low
    a_r3_clear_lands: assert property (@(posedge clk) disable iff (!rst_n)
        clr_hit |=> ((req & $past(wr_bits)) == '0));

    // R3: zero data bits in a clear write leave the other requests as they were
    a_r3_clear_only_marked: assert property (@(posedge clk) disable iff (!rst_n)
        clr_hit |=> ((req & ~$past(wr_bits)) == ($past(req) & ~$past(wr_bits))));

endmodule

// File: rtl/dps_stage.sv
// A simple sequencing stage. Its run state follows the request one cycle
// later, and only while the gate (the status of the stage it depends on)
// is high. The run state doubles as the enable output and the status bit.
module dps_stage (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic gate,
    output logic run
);

    // Update the run state from the request and its prerequisite.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run <= 1'b0;
        end else begin
            run <= req && gate;
        end
    end

endmodule

// File: rtl/dps_disp.sv
// Panel enable stage. It waits for sync status and the panel request,
// then counts frame-start pulses up to the guard count before it raises
// the pin. A cleared request lowers the pin at the next frame start.
// Loss of sync lowers it at once. Assumes frame_start is a one-cycle pulse.
module dps_disp #(
    parameter  int GUARD_W = 8,
    localparam int CMP_W   = GUARD_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req,
    input  logic               sync_sts,
    input  logic               frame_start,
    input  logic [GUARD_W-1:0] guard,
    input  logic               delay_en,
    output logic               run
);

    logic [GUARD_W-1:0] frames;
    logic [CMP_W-1:0]   frames_nx;
    logic               no_wait;

    // Next frame count, widened so that the compare cannot wrap.
    always_comb begin
        frames_nx = {1'b0, frames} + CMP_W'(1);
        no_wait   = !delay_en || (guard == '0);
    end

    // Pin state and guard frame counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run    <= 1'b0;
            frames <= '0;
        end else if (!sync_sts) begin
            run    <= 1'b0;
            frames <= '0;
        end else if (run) begin
            frames <= '0;
            if (!req && frame_start) begin
                run <= 1'b0;
            end
        end else if (req) begin
            if (no_wait) begin
                run <= 1'b1;
            end else if (frame_start) begin
                if (frames_nx >= {1'b0, guard}) begin
                    run    <= 1'b1;
                    frames <= '0;
                end else begin
                    frames <= frames_nx[GUARD_W-1:0];
                end
            end
        end else begin
            frames <= '0;
        end
    end

    // R6: the pin only rises while sync was running
    a_r6_needs_sync: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run) |-> $past(sync_sts));

    // R6: with the guard delay active, a rise is always caused by a frame pulse
    a_r6_rise_on_frame: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(run) && $past(delay_en) && ($past(guard) != '0)) |-> $past(frame_start));

    // R8: the pin falls only at a frame boundary or after sync is lost
    a_r8_fall_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(run) |-> ($past(frame_start) || !$past(sync_sts)));

    // R8: while sync is running and the request holds, the pin never drops
    a_r8_hold_while_requested: assert property (@(posedge clk) disable iff (!rst_n)
        (run && req && sync_sts) |=> run);

endmodule

// File: rtl/disp_pwr_seq.sv
// Display power sequencer top. It connects the register file, three
// simple stages (clock, sync gated by clock status, PWM) and the panel
// enable stage. Status bits are the run states of the stages.
module disp_pwr_seq
    import disp_pwr_seq_pkg::*;
#(
    parameter  int GUARD_W = 8,
    localparam int DATA_W  = GUARD_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              frame_start,
    output logic              pclk_en,
    output logic              sync_en,
    output logic              disp_pin,
    output logic              pwm_en,
    output logic              vsync_shift
);

    logic [NUM_STAGES-1:0] req;
    logic [NUM_STAGES-1:0] run;
    logic [NUM_STAGES-1:0] gate;
    logic [GUARD_W-1:0]    guard;
    logic                  delay_en;

    dps_regs #(.GUARD_W(GUARD_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .rd_addr     (rd_addr),
        .status      (run),
        .rd_data     (rd_data),
        .req         (req),
        .guard       (guard),
        .delay_en    (delay_en),
        .vsync_shift (vsync_shift)
    );

    // Prerequisite of each stage: sync needs the clock, the others stand alone.
    always_comb begin
        gate           = '1;
        gate[STG_SYNC] = run[STG_CLK];
    end

    // Simple stages are built in a loop; the panel stage has its own module.
    for (genvar s = 0; s < NUM_STAGES; s++) begin : g_stage
        if (s == STG_DISP) begin : g_disp
            dps_disp #(.GUARD_W(GUARD_W)) u_disp (
                .clk         (clk),
                .rst_n       (rst_n),
                .req         (req[s]),
                .sync_sts    (run[STG_SYNC]),
                .frame_start (frame_start),
                .guard       (guard),
                .delay_en    (delay_en),
                .run         (run[s])
            );
        end else begin : g_plain
            dps_stage u_stage (
                .clk   (clk),
                .rst_n (rst_n),
                .req   (req[s]),
                .gate  (gate[s]),
                .run   (run[s])
            );
        end
    end

    // Drive the stage enables from the run states.
    always_comb begin
        pclk_en  = run[STG_CLK];
        sync_en  = run[STG_SYNC];
        disp_pin = run[STG_DISP];
        pwm_en   = run[STG_PWM];
    end

    // R5: sync only runs if the clock ran on the cycle before
    a_r5_sync_after_clk: assert property (@(posedge clk) disable iff (!rst_n)
        sync_en |-> $past(pclk_en));

    // R4: the clock enable changes only one cycle after its request did
    a_r4_clk_lag: assert property (@(posedge clk) disable iff (!rst_n)
        (pclk_en != $past(pclk_en)) |-> (pclk_en == $past(req[STG_CLK])));

    // R9: PWM tracks its own request regardless of the other stages
    a_r9_pwm_follow: assert property (@(posedge clk) disable iff (!rst_n)
        req[STG_PWM] |=> pwm_en);

    // R1: the status read is zero on the cycle after reset
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (run == '0));

endmodule

// File: tb/disp_pwr_seq_bench.sv
`timescale 1ns/1ps
module disp_pwr_seq_bench;
    localparam int GW = 8;
    localparam int DW = GW + 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [1:0]    rd_addr = '0;
    logic          fs = 1'b0;
    logic [DW-1:0] rd_data;
    logic          pclk_en, sync_en, disp_pin, pwm_en, vsync_shift;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    disp_pwr_seq #(.GUARD_W(GW)) u_disp_pwr_seq (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .frame_start(fs), .pclk_en(pclk_en), .sync_en(sync_en),
        .disp_pin(disp_pin), .pwm_en(pwm_en), .vsync_shift(vsync_shift)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference model, updated at every rising edge.
    bit m_req[4];
    bit m_clk, m_sync, m_disp, m_pwm, m_dly, m_vs;
    int m_cnt, m_guard;

    always @(posedge clk) begin : model
        bit nclk, nsync, ndisp, npwm;
        int ncnt;
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) m_req[i] = 1'b0;
            m_clk = 0; m_sync = 0; m_disp = 0; m_pwm = 0;
            m_cnt = 0; m_guard = 1; m_dly = 1; m_vs = 0;
        end else begin
            nclk  = m_req[0];
            nsync = m_req[1] && m_clk;
            npwm  = m_req[3];
            ndisp = m_disp;
            ncnt  = m_cnt;
            if (!m_sync) begin
                ndisp = 0; ncnt = 0;
            end else if (m_disp) begin
                ncnt = 0;
                if (!m_req[2] && fs) ndisp = 0;
            end else if (m_req[2]) begin
                if (!m_dly || m_guard == 0) ndisp = 1;
                else if (fs) begin
                    if (m_cnt + 1 >= m_guard) begin ndisp = 1; ncnt = 0; end
                    else ncnt = m_cnt + 1;
                end
            end else ncnt = 0;
            if (wr_en) begin
                case (wr_addr)
                    2'd0: for (int i = 0; i < 4; i++) if (wr_data[i]) m_req[i] = 1'b1;
                    2'd1: for (int i = 0; i < 4; i++) if (wr_data[i]) m_req[i] = 1'b0;
                    2'd3: begin
                        m_guard = int'(wr_data[GW-1:0]);
                        m_dly   = wr_data[GW];
                        m_vs    = wr_data[GW+1];
                    end
                    default: ;
                endcase
            end
            m_clk = nclk; m_sync = nsync; m_disp = ndisp; m_pwm = npwm; m_cnt = ncnt;
        end
    end

    function automatic int exp_rd(input logic [1:0] a);
        case (a)
            2'd0: return {m_req[3], m_req[2], m_req[1], m_req[0]};
            2'd2: return {m_pwm, m_disp, m_sync, m_clk};
            2'd3: return (int'(m_vs) << (GW + 1)) | (int'(m_dly) << GW) | m_guard;
            default: return 0;
        endcase
    endfunction

    // Compare every output against the model, away from the clock edge.
    always @(posedge clk) begin
        #1;
        if (!done) begin
            check(pclk_en == m_clk, "R4 pclk_en", pclk_en, m_clk);
            check(sync_en == m_sync, "R5 sync_en", sync_en, m_sync);
            check(disp_pin == m_disp, "R6 disp_pin", disp_pin, m_disp);
            check(pwm_en == m_pwm, "R9 pwm_en", pwm_en, m_pwm);
            check(vsync_shift == m_vs, "R10 vsync_shift", vsync_shift, m_vs);
            check(int'(rd_data) == exp_rd(rd_addr), "R11 rd_data", rd_data, exp_rd(rd_addr));
        end
    end

    task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse();
        fs = 1'b1;
        @(negedge clk);
        fs = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, input int exp, input string tag);
        rd_addr = a;
        #1;
        check(int'(rd_data) == exp, tag, rd_data, exp);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check({pclk_en, sync_en, disp_pin, pwm_en} == 4'b0, "R1 outputs", pclk_en, 0);
        rd(2'd2, 0, "R1 status");
        rd(2'd3, 'h101, "R1 ctrl");
        // R5 sync request held while clock is off
        wr(2'd0, 'h2);
        repeat (3) @(negedge clk);
        check(sync_en == 1'b0, "R5 pending", sync_en, 0);
        rd(2'd0, 'h2, "R2 set readback");
        // R4 clock lag, then R5 sync start
        wr(2'd0, 'h1);
        check(pclk_en == 1'b0, "R4 lag", pclk_en, 0);
        @(negedge clk);
        check(pclk_en == 1'b1, "R4 on", pclk_en, 1);
        check(sync_en == 1'b0, "R5 not yet", sync_en, 0);
        @(negedge clk);
        check(sync_en == 1'b1, "R5 on", sync_en, 1);
        // R2 zero write no effect
        wr(2'd0, 'h0);
        rd(2'd0, 'h3, "R2 zero write");
        // R10 control load, guard 3
        wr(2'd3, 'h303);
        check(vsync_shift == 1'b1, "R10 vsync", vsync_shift, 1);
        rd(2'd3, 'h303, "R10 ctrl readback");
        // R6 guard of three frames
        wr(2'd0, 'h4);
        @(negedge clk);
        pulse(); pulse();
        check(disp_pin == 1'b0, "R6 before guard", disp_pin, 0);
        pulse();
        check(disp_pin == 1'b1, "R6 after guard", disp_pin, 1);
        rd(2'd2, 'h7, "R11 status");
        // R9 PWM
        wr(2'd0, 'h8);
        @(negedge clk);
        check(pwm_en == 1'b1, "R9 pwm on", pwm_en, 1);
        // R8 disable waits for frame boundary
        wr(2'd1, 'h4);
        repeat (3) @(negedge clk);
        check(disp_pin == 1'b1, "R8 held", disp_pin, 1);
        pulse();
        check(disp_pin == 1'b0, "R8 frame drop", disp_pin, 0);
        // R7 guard zero
        wr(2'd3, 'h100);
        wr(2'd0, 'h4);
        @(negedge clk);
        check(disp_pin == 1'b1, "R7 guard zero", disp_pin, 1);
        wr(2'd1, 'h4);
        pulse();
        // R7 delay bit off
        wr(2'd3, 'h005);
        wr(2'd0, 'h4);
        @(negedge clk);
        check(disp_pin == 1'b1, "R7 delay off", disp_pin, 1);
        // R8 sync loss drops the pin at once
        wr(2'd1, 'h2);
        @(negedge clk);
        check(sync_en == 1'b0, "R5 off", sync_en, 0);
        @(negedge clk);
        check(disp_pin == 1'b0, "R8 sync loss", disp_pin, 0);
        // R3 zero clear no effect, then clock off
        wr(2'd1, 'h0);
        rd(2'd0, 'hD, "R3 zero clear");
        wr(2'd1, 'h1);
        @(negedge clk);
        check(pclk_en == 1'b0, "R3 clock cleared", pclk_en, 0);
        rd(2'd1, 0, "R11 clear reads zero");
        // Random phase against the model
        for (int n = 0; n < 3000; n++) begin
            @(negedge clk);
            wr_en   = ($urandom % 3) == 0;
            wr_addr = 2'($urandom);
            wr_data = DW'($urandom);
            if (wr_addr == 2'd3) wr_data[GW-1:0] = GW'($urandom % 4);
            fs      = ($urandom % 5) == 0;
            rd_addr = 2'($urandom);
        end
        @(negedge clk);
        wr_en = 1'b0; fs = 1'b0;
        repeat (2) @(negedge clk);
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            summary();
            $finish;
        end
    end

endmodule